// File: doc/BRIEF.md
# Energize-then-Chop Gate Controller

This block turns eight per-channel on/off bits into eight gate-enable waveforms for inductive loads. When a channel's bit rises, the channel drives fully on for a programmed hold-in time, then settles into a lower-power pattern. That pattern is either chopping at a programmed duty or switching off. All channels share one 8-bit settings word. The settings word holds a timer-enable flag, a 3-bit duty code and a 4-bit hold-in code. The hold-in code selects from a fixed nonlinear table of millisecond counts. Time is measured by counting a one-cycle millisecond strobe supplied from outside.

A shared start pulse ends the hold-in phase early on every channel that is still in it. When the timer flag is clear, a channel that is never given a start pulse stays fully on. Once its hold-in time has run out, it ignores later start pulses. A per-channel block mask and a global disable force gates low without disturbing the phase state. When they are released, each channel continues where it was.

Top module: `gate_phase_ctrl`

## Requirements
- R1: After reset every gate output is low and every channel is idle.
- R2: With the timer flag (settings bit 7) at 0 and no start pulse, a channel whose bit has risen drives its gate high continuously. This holds both before and after its hold-in time has elapsed.
- R3: The hold-in code (settings bits 3:0) maps codes 0..15 to 0, 3, 5, 10, 15, 20, 30, 50, 80, 110, 140, 170, 200, 230, 260 and 300 strobes. With the timer flag at 1 and a nonzero code, the gate stays high until that many strobes have been seen since the channel turned on. The channel then chops from the cycle after the last strobe.
- R4: With the timer flag at 1 and hold-in code 0, a channel that turns on goes straight to chopping in the next cycle.
- R5: While chopping, the gate is high for exactly duty-code (settings bits 6:4) slots of every 8-slot period. Each slot lasts PRESCALE clock cycles. Duty code 0 therefore leaves the gate low after the hold-in time.
- R6: A start pulse seen while a channel is in its hold-in phase moves it to chopping in the next cycle. A channel whose hold-in time has already expired with the timer flag at 0 ignores the pulse and stays fully on.
- R7: A channel whose bit is low drives its gate low from the next cycle on and returns to idle. A new rising edge restarts its hold-in timer from zero.
- R8: A set bit in the block mask, or the global disable, holds the matching gates low at once. Releasing it restores the waveform that the channel's phase calls for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_on | input | NCH | Per-channel on/off bits |
| ctrl | input | 8 | Shared settings: [7] timer flag, [6:4] duty code, [3:0] hold-in code |
| pwm_go | input | 1 | One-cycle start pulse that ends hold-in early |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| force_off | input | NCH | Per-channel block mask |
| all_off | input | 1 | Global disable |
| gate | output | NCH | Gate-enable outputs |

## Verification
A channel stuck in the wrong phase shows at its gate within one chopping period. A stuck hold-in phase reads as a constant high where the gate should toggle. A premature exit from hold-in shows as toggling or low before the strobe count is reached. An off-by-one in the hold-in counter moves the falling gate edge by exactly one strobe, so the bench samples just before and just after the final strobe. A wrong duty or slot counter changes the number of high cycles per 8·PRESCALE window, and the bench counts that number directly.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

    localparam int SLOT_W  = 3;
    localparam int HOLD_W  = 9;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_HOLD  = 2'd1,
        PH_CHOP  = 2'd2,
        PH_FULL  = 2'd3
    } phase_t;

    typedef struct packed {
        logic       tmr_en;
        logic [2:0] duty;
        logic [3:0] hcode;
    } settings_t;

    function automatic logic [HOLD_W-1:0] hold_len(input logic [3:0] code);
        logic [HOLD_W-1:0] v;
        case (code)
            4'd0:  v = 9'd0;
            4'd1:  v = 9'd3;
            4'd2:  v = 9'd5;
            4'd3:  v = 9'd10;
            4'd4:  v = 9'd15;
            4'd5:  v = 9'd20;
            4'd6:  v = 9'd30;
            4'd7:  v = 9'd50;
            4'd8:  v = 9'd80;
            4'd9:  v = 9'd110;
            4'd10: v = 9'd140;
            4'd11: v = 9'd170;
            4'd12: v = 9'd200;
            4'd13: v = 9'd230;
            4'd14: v = 9'd260;
            default: v = 9'd300;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/gpc_slot_gen.sv
module gpc_slot_gen
    import gpc_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PW-1:0] pre_q;
    logic          wrap;

    assign wrap = (pre_q == PW'(PRESCALE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            slot  <= '0;
        end else begin
            pre_q <= wrap ? '0 : pre_q + 1'b1;
            if (wrap) slot <= slot + 1'b1;
        end
    end
endmodule

// File: rtl/gpc_chan.sv
module gpc_chan
    import gpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              on,
    input  settings_t         cfg,
    input  logic              pwm_go,
    input  logic              ms_tick,
    input  logic [SLOT_W-1:0] slot,
    input  logic              block,
    output logic              gate,
    output phase_t            phase
);
    logic [HOLD_W-1:0] cnt_q;
    logic [HOLD_W-1:0] limit;
    logic              expire;
    logic              drive;

    assign limit  = hold_len(cfg.hcode);
    assign expire = ms_tick && ((cnt_q + 1'b1) >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
        end else if (!on) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (cfg.hcode == 4'd0)
                        phase <= cfg.tmr_en ? PH_CHOP : PH_FULL;
                    else
                        phase <= PH_HOLD;
                end
                PH_HOLD: begin
                    if (pwm_go)
                        phase <= PH_CHOP;
                    else if (expire)
                        phase <= cfg.tmr_en ? PH_CHOP : PH_FULL;
                    else if (ms_tick)
                        cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (phase)
            PH_HOLD, PH_FULL: drive = 1'b1;
            PH_CHOP:          drive = ({1'b0, slot} < {1'b0, cfg.duty});
            default:          drive = 1'b0;
        endcase
    end

    assign gate = drive && !block;
endmodule

// File: rtl/gate_phase_ctrl.sv
module gate_phase_ctrl
    import gpc_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int PRESCALE = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] chan_on,
    input  logic [7:0]     ctrl,
    input  logic           pwm_go,
    input  logic           ms_tick,
    input  logic [NCH-1:0] force_off,
    input  logic           all_off,
    output logic [NCH-1:0] gate
);
    settings_t         cfg;
    logic [SLOT_W-1:0] slot;
    phase_t [NCH-1:0]  ph_vec;

    assign cfg = settings_t'(ctrl);

    gpc_slot_gen #(.PRESCALE(PRESCALE)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        gpc_chan u_ch (
            .clk     (clk),
            .rst     (rst),
            .on      (chan_on[i]),
            .cfg     (cfg),
            .pwm_go  (pwm_go),
            .ms_tick (ms_tick),
            .slot    (slot),
            .block   (force_off[i] || all_off),
            .gate    (gate[i]),
            .phase   (ph_vec[i])
        );
    end
endmodule

// File: rtl/gpc_chk.sv
module gpc_chk
    import gpc_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [NCH-1:0]   chan_on,
    input logic [7:0]       ctrl,
    input logic             pwm_go,
    input logic [NCH-1:0]   force_off,
    input logic             all_off,
    input logic [NCH-1:0]   gate,
    input phase_t [NCH-1:0] ph_vec
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        AST_MASK_LOW: assert property (@(posedge clk) disable iff (rst)
            (force_off[i] || all_off) |-> !gate[i]); // R8
        AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
            !$past(chan_on[i]) |-> (ph_vec[i] == PH_IDLE)); // R7
        AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
            (ph_vec[i] == PH_FULL && chan_on[i]) |=> (ph_vec[i] == PH_FULL)); // R6
        AST_ZERO_CODE_CHOP: assert property (@(posedge clk) disable iff (rst)
            (ph_vec[i] == PH_IDLE && chan_on[i] && ctrl[7] && ctrl[3:0] == 4'd0)
            |=> (ph_vec[i] == PH_CHOP)); // R4
        AST_START_HOLD: assert property (@(posedge clk) disable iff (rst)
            (ph_vec[i] == PH_IDLE && chan_on[i] && ctrl[3:0] != 4'd0)
            |=> (ph_vec[i] == PH_HOLD)); // R3
        AST_GO_CHOP: assert property (@(posedge clk) disable iff (rst)
            (ph_vec[i] == PH_HOLD && chan_on[i] && pwm_go)
            |=> (ph_vec[i] == PH_CHOP)); // R6
    end
endmodule

bind gate_phase_ctrl gpc_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .chan_on   (chan_on),
    .ctrl      (ctrl),
    .pwm_go    (pwm_go),
    .force_off (force_off),
    .all_off   (all_off),
    .gate      (gate),
    .ph_vec    (ph_vec)
);

// File: tb/sim_gate_phase_ctrl.sv
module sim_gate_phase_ctrl;
    localparam int NCH = 8;
    localparam int PS  = 4;
    localparam int WIN = 8 * PS;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] chan_on = '0;
    logic [7:0]     ctrl = '0;
    logic           pwm_go = 1'b0;
    logic           ms_tick = 1'b0;
    logic [NCH-1:0] force_off = '0;
    logic           all_off = 1'b0;
    logic [NCH-1:0] gate;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gate_phase_ctrl #(.NCH(NCH), .PRESCALE(PS)) u0 (
        .clk(clk), .rst(rst), .chan_on(chan_on), .ctrl(ctrl),
        .pwm_go(pwm_go), .ms_tick(ms_tick), .force_off(force_off),
        .all_off(all_off), .gate(gate)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic go_pulse();
        @(negedge clk) pwm_go = 1'b1;
        @(negedge clk) pwm_go = 1'b0;
    endtask

    task automatic count_high(input int ch, input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            c += int'(gate[ch]);
        end
    endtask

    task automatic turn_on(input int ch);
        @(negedge clk) chan_on[ch] = 1'b1;
        @(negedge clk);
    endtask

    task automatic all_idle();
        @(negedge clk) chan_on = '0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 gates after reset", int'(gate), 0);
    endtask

    task automatic t_no_timer();
        int c;
        ctrl = 8'b0_011_0001;
        turn_on(0);
        chk("R2 full on at start", int'(gate[0]), 1);
        tick(3);
        count_high(0, WIN, c);
        chk("R2 full on after hold time", c, WIN);
        go_pulse();
        count_high(0, WIN, c);
        chk("R6 start ignored after expiry", c, WIN);
        @(negedge clk) chan_on[0] = 1'b0;
        @(negedge clk);
        chk("R7 gate low after bit low", int'(gate[0]), 0);
        all_idle();
    endtask

    task automatic t_timer_chop();
        int c;
        ctrl = 8'b1_101_0001;
        turn_on(1);
        tick(2);
        count_high(1, WIN, c);
        chk("R3 full before 3rd strobe", c, WIN);
        tick(1);
        count_high(1, WIN, c);
        chk("R5 duty 5 after hold", c, 5 * PS);
        all_idle();
    endtask

    task automatic t_zero_code();
        int c;
        ctrl = 8'b1_010_0000;
        turn_on(2);
        count_high(2, WIN, c);
        chk("R4 code 0 chops at once (duty 2)", c, 2 * PS);
        ctrl = 8'b1_111_0000;
        count_high(2, WIN, c);
        chk("R5 duty 7", c, 7 * PS);
        all_idle();
    endtask

    task automatic t_duty_off();
        int c;
        ctrl = 8'b1_000_0010;
        turn_on(3);
        tick(4);
        chk("R3 code 2 still on after 4 strobes", int'(gate[3]), 1);
        tick(1);
        count_high(3, WIN, c);
        chk("R5 duty 0 off after 5 strobes", c, 0);
        all_idle();
        ctrl = 8'b1_000_1111;
        turn_on(3);
        tick(299);
        chk("R3 code 15 still on after 299 strobes", int'(gate[3]), 1);
        tick(1);
        chk("R3 code 15 off after 300 strobes", int'(gate[3]), 0);
        all_idle();
    endtask

    task automatic t_start();
        int c;
        ctrl = 8'b0_110_0011;
        turn_on(4);
        tick(2);
        chk("R6 on during hold", int'(gate[4]), 1);
        go_pulse();
        count_high(4, WIN, c);
        chk("R6 start pulse gives duty 6", c, 6 * PS);
        all_idle();
    endtask

    task automatic t_restart();
        ctrl = 8'b1_000_0001;
        turn_on(5);
        tick(2);
        @(negedge clk) chan_on[5] = 1'b0;
        @(negedge clk);
        chk("R7 low when bit dropped", int'(gate[5]), 0);
        turn_on(5);
        tick(2);
        chk("R7 timer restarted", int'(gate[5]), 1);
        tick(1);
        chk("R7 expiry after fresh count", int'(gate[5]), 0);
        all_idle();
    endtask

    task automatic t_force();
        ctrl = 8'b0_000_0000;
        turn_on(6);
        turn_on(7);
        @(negedge clk) force_off[6] = 1'b1;
        @(negedge clk);
        chk("R8 masked channel low", int'(gate[6]), 0);
        chk("R8 unmasked channel high", int'(gate[7]), 1);
        @(negedge clk) all_off = 1'b1;
        @(negedge clk);
        chk("R8 global disable", int'(gate), 0);
        @(negedge clk) begin all_off = 1'b0; force_off = '0; end
        @(negedge clk);
        chk("R8 release restores", int'(gate[7:6]), 3);
        all_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_timer();
        t_timer_chop();
        t_zero_code();
        t_duty_off();
        t_start();
        t_restart();
        t_force();
        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 100000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule